// File: doc/BRIEF.md
# Weighted and Transition-Density Scan Bit Generator

This block feeds serial stimulus into the scan chains of a self-testing circuit. One 28-bit shift register with external feedback produces pseudo-random cells. For each scan chain, a small gate network combines some of those cells into eight bit streams whose probability of being 1 ranges from one eighth to seven eighths. A 3-bit select picks one stream.

The picked bit is offered in two forms. The first is the weighted-random bit itself. The second is a transition-density bit: a toggle register flips whenever the picked bit is 1, so its toggle rate equals the chosen weight. A mode input decides which of the two forms drives the scan-in output.

Every chain gets its own copy of the network. Each copy reads the shared register through a rotated cell map, so that neighbouring chains see different bits. The register only advances on cycles where the shift enable is high. A nonzero seed can be loaded at any time, and a zero seed is refused, so the register can never lock up in the all-zero state.

Top module: `wsg_scan_gen`

## Requirements
- R1: On a clock edge with `rst` high, the register state becomes the `SEED` parameter (default 28'h9E37A15), and all of `wrp_o`, `tdp_o` and `scan_o` become 0.
- R2: On an enabled shift, the 28-bit state s advances to {s[26:0], s[27]^s[2]}. This is the recurrence of the polynomial x^28+x^3+1.
- R3: For chain 0, define the cell terms as follows:
  - a=s[1], b=s[9], c=s[13], d=s[20], e=s[25], f=s[17], g=s[5], h=s[5].
  - The weighted bits built from them are:
    - q25 = a&b
    - q125 = a term of three cells, c&d&e
    - q75 = ~q25
    - q875 = ~q125
    - q375 = q75&f
    - q625 = ~q375
    - q4375 = q875&g
    - q5 = h
  - `wsel` values 0 to 7 select q125, q25, q375, q4375, q5, q625, q75 and q875, in that order.
- R4: Chain k uses cell index (t + 7·k) mod 28 wherever chain 0 uses cell t.
- R5: On an enabled shift, each chain's `wrp_o` bit registers the selected bit computed from the state held before that edge.
- R6: On an enabled shift, `tdp_o` of a chain toggles exactly when its selected bit is 1, and holds otherwise.
- R7: On an enabled shift, `scan_o` takes the new `tdp_o` value when `mode` is 1, and the new `wrp_o` value when `mode` is 0.
- R8: With `en` low and no seed load, the state and all outputs hold.
- R9: `seed_ld` with a nonzero `seed` loads the state on that edge and takes priority over `en`. All outputs hold on that edge.
- R10: `seed_ld` with `seed` equal to 0 is ignored. The state then shifts or holds according to `en`, as if no load had been requested.
- R11: Over 3000 enabled shifts at a fixed `wsel`, both of the following lie within 0.04 of the selected weight:
  - the fraction of ones on `wrp_o[0]`;
  - the toggle rate of `tdp_o[0]`.
- R12: The register state is never all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Shift enable, one bit per chain per enabled cycle |
| seed_ld | input | 1 | Load `seed` into the register (ignored if zero) |
| seed | input | W (28) | Seed value |
| wsel | input | 3 | Weight select |
| mode | input | 1 | 0 drives the weighted bit to `scan_o`, 1 drives the toggle bit |
| wrp_o | output | CHAINS | Registered weighted-random bit per chain |
| tdp_o | output | CHAINS | Registered transition-density bit per chain |
| scan_o | output | CHAINS | Registered scan-in bit per chain |

## Verification
The bench builds the block with CHAINS=3 and keeps the default PERM_STEP of 7. This exercises rotation offsets 0, 7 and 14. The rotated maps are therefore checked against the shared register, including a map whose indices wrap past cell 27. A behavioural model of the recurrence and of the weight formulas is compared with every chain on every cycle through all eight selects and both modes. Long runs at each select then measure the ones fraction and the toggle rate on chain 0 against the nominal weights.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int unsigned LFSR_W   = 28;
  localparam int unsigned FB_TAP   = 2;   // x^3 term
  localparam int unsigned N_WEIGHT = 8;
  localparam int unsigned SEL_W    = $clog2(N_WEIGHT);

  // base cell indices for chain 0
  localparam int unsigned T_A = 1;
  localparam int unsigned T_B = 9;
  localparam int unsigned T_C = 13;
  localparam int unsigned T_D = 20;
  localparam int unsigned T_E = 25;
  localparam int unsigned T_F = 17;
  localparam int unsigned T_G = 5;
  localparam int unsigned T_H = 5;
endpackage

// File: rtl/wsg_lfsr.sv
module wsg_lfsr #(
  parameter int unsigned W    = 28,
  parameter int unsigned TAP  = 2,
  parameter logic [W-1:0] SEED = 28'h9E37A15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst)
      st_q <= SEED;
    else if (load)
      st_q <= load_val;
    else if (shift)
      st_q <= {st_q[W-2:0], st_q[W-1] ^ st_q[TAP]};
  end

  assign state = st_q;
endmodule

// File: rtl/wsg_weight_net.sv
module wsg_weight_net
  import wsg_pkg::*;
#(
  parameter int unsigned W      = 28,
  parameter int unsigned OFFSET = 0
) (
  input  logic [W-1:0]     cells,
  input  logic [SEL_W-1:0] wsel,
  output logic             wbit
);
  localparam int unsigned IA = (T_A + OFFSET) % W;
  localparam int unsigned IB = (T_B + OFFSET) % W;
  localparam int unsigned IC = (T_C + OFFSET) % W;
  localparam int unsigned ID = (T_D + OFFSET) % W;
  localparam int unsigned IE = (T_E + OFFSET) % W;
  localparam int unsigned IF = (T_F + OFFSET) % W;
  localparam int unsigned IG = (T_G + OFFSET) % W;
  localparam int unsigned IH = (T_H + OFFSET) % W;

  logic q25, q125, q75, q875, q375, q625, q4375, q5;
  logic [N_WEIGHT-1:0] streams;

  always_comb begin
    q25   = cells[IA] & cells[IB];
    q125  = cells[IC] & cells[ID] & cells[IE];
    q75   = ~q25;
    q875  = ~q125;
    q375  = q75 & cells[IF];
    q625  = ~q375;
    q4375 = q875 & cells[IG];
    q5    = cells[IH];
    // ascending weight order
    streams = {q875, q75, q625, q5, q4375, q375, q25, q125};
    wbit    = streams[wsel];
  end
endmodule

// File: rtl/wsg_lane.sv
module wsg_lane
  import wsg_pkg::*;
#(
  parameter int unsigned W      = 28,
  parameter int unsigned OFFSET = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             mode,
  input  logic [SEL_W-1:0] wsel,
  input  logic [W-1:0]     cells,
  output logic             wrp_o,
  output logic             tdp_o,
  output logic             scan_o
);
  logic sel_bit;
  logic wrp_q, tdp_q, scan_q;
  logic tdp_nxt;

  wsg_weight_net #(.W(W), .OFFSET(OFFSET)) u_net (
    .cells(cells),
    .wsel (wsel),
    .wbit (sel_bit)
  );

  assign tdp_nxt = tdp_q ^ sel_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrp_q  <= 1'b0;
      tdp_q  <= 1'b0;
      scan_q <= 1'b0;
    end else if (shift) begin
      wrp_q  <= sel_bit;
      tdp_q  <= tdp_nxt;
      scan_q <= mode ? tdp_nxt : sel_bit;
    end
  end

  assign wrp_o  = wrp_q;
  assign tdp_o  = tdp_q;
  assign scan_o = scan_q;
endmodule

// File: rtl/wsg_scan_gen.sv
module wsg_scan_gen
  import wsg_pkg::*;
#(
  parameter int unsigned  W         = 28,
  parameter int unsigned  CHAINS    = 2,
  parameter int unsigned  PERM_STEP = 7,
  parameter logic [W-1:0] SEED      = 28'h9E37A15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              seed_ld,
  input  logic [W-1:0]      seed,
  input  logic [2:0]        wsel,
  input  logic              mode,
  output logic [CHAINS-1:0] wrp_o,
  output logic [CHAINS-1:0] tdp_o,
  output logic [CHAINS-1:0] scan_o
);
  logic [W-1:0] lfsr_q;
  logic         load_ok;
  logic         shift;

  assign load_ok = seed_ld && (seed != '0);
  assign shift   = en && !load_ok;

  wsg_lfsr #(.W(W), .TAP(FB_TAP), .SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .shift   (shift),
    .load    (load_ok),
    .load_val(seed),
    .state   (lfsr_q)
  );

  for (genvar k = 0; k < CHAINS; k++) begin : g_lane
    wsg_lane #(.W(W), .OFFSET((k * PERM_STEP) % W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .shift (shift),
      .mode  (mode),
      .wsel  (wsel),
      .cells (lfsr_q),
      .wrp_o (wrp_o[k]),
      .tdp_o (tdp_o[k]),
      .scan_o(scan_o[k])
    );
  end
endmodule

// File: rtl/wsg_scan_gen_chk.sv
module wsg_scan_gen_chk #(
  parameter int unsigned  W      = 28,
  parameter int unsigned  CHAINS = 2,
  parameter logic [W-1:0] SEED   = 28'h9E37A15
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              seed_ld,
  input logic [W-1:0]      seed,
  input logic              mode,
  input logic [W-1:0]      lfsr_q,
  input logic [CHAINS-1:0] wrp_o,
  input logic [CHAINS-1:0] tdp_o,
  input logic [CHAINS-1:0] scan_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (lfsr_q == SEED && wrp_o == '0 && tdp_o == '0 && scan_o == '0));

  // R6
  tdp_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !(seed_ld && seed != '0)) |=> (tdp_o == ($past(tdp_o) ^ wrp_o)));

  // R7
  mode_route_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !(seed_ld && seed != '0)) |=> (scan_o == ($past(mode) ? tdp_o : wrp_o)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !seed_ld) |=> ($stable(lfsr_q) && $stable(tdp_o) && $stable(scan_o)));

  // R9
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_ld && seed != '0) |=> (lfsr_q == $past(seed) && $stable(wrp_o) && $stable(tdp_o)));

  // R10
  zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_ld && seed == '0 && !en) |=> $stable(lfsr_q));

  // R12
  nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
endmodule

bind wsg_scan_gen wsg_scan_gen_chk #(.W(W), .CHAINS(CHAINS), .SEED(SEED)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .seed_ld(seed_ld),
  .seed   (seed),
  .mode   (mode),
  .lfsr_q (lfsr_q),
  .wrp_o  (wrp_o),
  .tdp_o  (tdp_o),
  .scan_o (scan_o)
);

// File: tb/sim_wsg_scan_gen.sv
module sim_wsg_scan_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 28;
  localparam int NC = 3;
  localparam logic [W-1:0] SEED = 28'h9E37A15;

  logic clk = 0, rst = 1, en = 0, seed_ld = 0, mode = 0;
  logic [W-1:0] seed = '0;
  logic [2:0] wsel = 3'd4;
  logic [NC-1:0] wrp_o, tdp_o, scan_o;

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsg_scan_gen #(.W(W), .CHAINS(NC), .PERM_STEP(7), .SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .en(en), .seed_ld(seed_ld), .seed(seed),
    .wsel(wsel), .mode(mode), .wrp_o(wrp_o), .tdp_o(tdp_o), .scan_o(scan_o));

  // behavioural reference
  logic [W-1:0] m_st;
  logic [NC-1:0] m_wrp, m_tdp, m_scan;

  function automatic int ix(int t, int ch);
    return (t + 7*ch) % 28;
  endfunction

  function automatic logic ref_bit(logic [W-1:0] s, int sel, int ch);
    logic p25, p125;
    p25  = s[ix(1,ch)] & s[ix(9,ch)];
    p125 = s[ix(13,ch)] & s[ix(20,ch)] & s[ix(25,ch)];
    case (sel)
      0: return p125;
      1: return p25;
      2: return !p25 && s[ix(17,ch)];
      3: return !p125 && s[ix(5,ch)];
      4: return s[ix(5,ch)];
      5: return !(!p25 && s[ix(17,ch)]);
      6: return !p25;
      default: return !p125;
    endcase
  endfunction

  function automatic real ref_w(int sel);
    case (sel)
      0: return 0.125; 1: return 0.25; 2: return 0.375; 3: return 0.4375;
      4: return 0.5;   5: return 0.625; 6: return 0.75; default: return 0.875;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = SEED; m_wrp = '0; m_tdp = '0; m_scan = '0;
    end else if (seed_ld && seed != 0) begin
      m_st = seed;
    end else if (en) begin
      for (int c = 0; c < NC; c++) begin
        logic b;
        b = ref_bit(m_st, int'(wsel), c);
        m_wrp[c]  = b;
        m_tdp[c]  = m_tdp[c] ^ b;
        m_scan[c] = mode ? m_tdp[c] : b;
      end
      m_st = {m_st[W-2:0], m_st[W-1] ^ m_st[2]};
    end
  end

  // per-cycle comparison, R2/R3/R4/R5/R6/R7
  always @(negedge clk) if (cmp_on && !done) begin
    for (int c = 0; c < NC; c++) begin
      n_chk++;
      if (wrp_o[c] !== m_wrp[c] || tdp_o[c] !== m_tdp[c] || scan_o[c] !== m_scan[c]) begin
        n_bad++;
        $display("FAIL R2/R3/R4/R5/R6/R7 chain %0d got wrp=%b tdp=%b scan=%b exp wrp=%b tdp=%b scan=%b",
                 c, wrp_o[c], tdp_o[c], scan_o[c], m_wrp[c], m_tdp[c], m_scan[c]);
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stats(int sel);
    int ones = 0, tog = 0;
    logic prev;
    real fo, ft, w;
    @(negedge clk); wsel = 3'(sel); en = 1;
    @(negedge clk); prev = tdp_o[0];
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ones += int'(wrp_o[0]);
      tog  += int'(tdp_o[0] != prev);
      prev = tdp_o[0];
    end
    w  = ref_w(sel);
    fo = real'(ones) / 3000.0;
    ft = real'(tog) / 3000.0;
    // R11 ones fraction and toggle rate
    chk((fo > w - 0.04) && (fo < w + 0.04), "R11 ones per mille", int'(fo*1000.0), int'(w*1000.0));
    chk((ft > w - 0.04) && (ft < w + 0.04), "R11 toggles per mille", int'(ft*1000.0), int'(w*1000.0));
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NC-1:0] h_w, h_t, h_s;
    cyc(3);
    @(negedge clk); rst = 0;
    // R1 reset values
    chk(wrp_o == 0 && tdp_o == 0 && scan_o == 0, "R1 outputs after reset",
        int'({wrp_o, tdp_o, scan_o}), 0);
    cmp_on = 1;
    en = 1; mode = 0; wsel = 3'd4; cyc(60);
    mode = 1; cyc(60);                               // R7
    for (int s = 0; s < 8; s++) begin wsel = 3'(s); cyc(30); end   // R3
    mode = 0;
    for (int s = 7; s >= 0; s--) begin wsel = 3'(s); cyc(20); end
    // R8 hold
    en = 0; h_w = wrp_o; h_t = tdp_o; h_s = scan_o; cyc(8);
    chk(wrp_o == h_w && tdp_o == h_t && scan_o == h_s, "R8 hold while idle",
        int'({wrp_o, tdp_o, scan_o}), int'({h_w, h_t, h_s}));
    // R9 load with en high: outputs hold on that edge
    en = 1; seed_ld = 1; seed = 28'h0123457; h_w = wrp_o; h_t = tdp_o;
    @(negedge clk); seed_ld = 0;
    chk(wrp_o == h_w && tdp_o == h_t, "R9 outputs held on load",
        int'({wrp_o, tdp_o}), int'({h_w, h_t}));
    mode = 1; cyc(40);
    // R10 zero seed ignored, both with en low and high
    en = 0; seed_ld = 1; seed = '0; cyc(3);
    en = 1; cyc(3); seed_ld = 0; cyc(40);
    chk(1, "R10 zero seed", 0, 0);
    // R11 statistics
    for (int s = 0; s < 8; s++) stats(s);
    // R1 reset mid-run
    @(negedge clk); rst = 1; cyc(2); rst = 0;
    chk(wrp_o == 0 && tdp_o == 0 && scan_o == 0, "R1 outputs after second reset",
        int'({wrp_o, tdp_o, scan_o}), 0);
    cyc(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule